// File: doc/BRIEF.md
# Multi-Channel Vectored Interrupt Controller

This block collects interrupt events from four serial channels and reports them to a host processor. The host uses an 8-bit data bus and one shared, active-low interrupt line. Each channel's datapath is outside the block and shows up here only as single-cycle event pulses, five cause lines per channel. Each channel stores its events in its own cause register. A per-cause mask hides selected causes. A channel mask hides whole channels. Hidden events are not lost: they stay pending and appear as soon as the mask that hides them is cleared.

The host services an interrupt in two reads. It first reads the vector register, which has one bit per channel with a visible interrupt. It then reads the cause register of the channel that the vector names. That second read clears the causes it returned. A configuration bit chooses which half of the data bus carries the vector, so that two devices can share one bus and one interrupt input. During a vector read the other half of the bus is not driven. The interrupt output is an open-drain pull-down request.

Top module: `chan_irq_hub`

## Requirements
- R1: A pulse on `evt[c*5+k]` for a channel and cause that are both unmasked sets cause bit k of channel c. From the next cycle on, `irq_drv_low` is 1 and bit c of the vector register is 1.
- R2: While `bus_rd` is high with address c (0 to 3), `bus_rdata[4:0]` returns channel c's visible causes and bits 7:5 read 0. At the clock edge the read clears those causes. `irq_drv_low` returns to 0 once no channel has a visible cause.
- R3: If a cause event arrives in the same cycle as a clearing read of that channel, the new event is kept. The cause bit stays set after the read.
- R4: Writing address 4+c sets channel c's cause mask from `bus_wdata[4:0]`, where a 1 masks that cause. A masked cause reads 0 in the cause register, does not set the vector, does not assert `irq_drv_low` and is not cleared by a read. It becomes visible once its mask bit is written back to 0.
- R5: Writing address 9 sets the channel mask from `bus_wdata[3:0]`, where a 1 hides the channel. A hidden channel reads 0 at its cause address and 0 in its vector bit. A read does not clear it, and it does not assert `irq_drv_low`. Its pending causes show again once it is unhidden.
- R6: Reading address 8 returns the vector. If configuration bit 0 (address 10) is 0, the vector sits on bits 3:0 and `bus_oe` = 0x0F. If it is 1, the vector sits on bits 7:4 and `bus_oe` = 0xF0. The bits that are not driven read 0.
- R7: Every read at an address other than 8 drives all eight bits (`bus_oe` = 0xFF), and unused addresses (11 to 15) read 0x00. When `bus_rd` is 0, `bus_oe` = 0x00.
- R8: After reset all causes, all masks and the configuration bit are 0, and `irq_drv_low` is 0.
- R9: A vector read clears nothing: with no events and no writes, the vector read after it has the same value.
- R10: A cause read clears only the addressed channel. Causes pending in other channels remain visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 20 | Event pulses, bit c*5+k is cause k of channel c |
| bus_rd | input | 1 | Read strobe; a cause read clears at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational during `bus_rd`) |
| bus_oe | output | 8 | Per-bit drive enable for the data bus |
| irq_drv_low | output | 1 | 1 = pull the shared interrupt line low |

## Verification
A wrong pending bit, mask bit or clear shows up at the ports in the cycle right after the edge that stored it. It appears in `irq_drv_low` at once, and in the next cause or vector read. The bench therefore checks the interrupt line on every cycle and compares every read against a reference model. Masked-and-pending state cannot be seen until a mask is cleared, so the directed cases unmask and read back straight after hiding events. The random phase writes masks often, so that lost or leaked pending bits surface within a few cycles.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int NCH    = 4;
    localparam int NCAUSE = 5;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int CHW    = $clog2(NCH);
    localparam int VSH    = DW - NCH;

    localparam logic [AW-1:0] A_VEC    = AW'(2 * NCH);
    localparam logic [AW-1:0] A_CHMASK = AW'(2 * NCH + 1);
    localparam logic [AW-1:0] A_CFG    = AW'(2 * NCH + 2);
    localparam logic [DW-1:0] VEC_OE_LO = DW'((1 << NCH) - 1);

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_CMASK,
        RK_VEC,
        RK_CHMASK,
        RK_CFG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CHW-1:0]   chan;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.chan = '0;
        if (a < AW'(NCH)) begin
            s.kind = RK_STAT;
            s.chan = CHW'(a);
        end else if (a < AW'(2 * NCH)) begin
            s.kind = RK_CMASK;
            s.chan = CHW'(a - AW'(NCH));
        end else if (a == A_VEC) begin
            s.kind = RK_VEC;
        end else if (a == A_CHMASK) begin
            s.kind = RK_CHMASK;
        end else if (a == A_CFG) begin
            s.kind = RK_CFG;
        end
        return s;
    endfunction
endpackage

// File: rtl/chan_irq_cell.sv
module chan_irq_cell #(
    parameter int NC = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NC-1:0] evt,
    input  logic          chan_hide,
    input  logic          clr,
    input  logic          mask_we,
    input  logic [NC-1:0] mask_wdata,
    output logic [NC-1:0] shown,
    output logic [NC-1:0] cmask
);
    logic [NC-1:0] pend_q;
    logic [NC-1:0] pend_d;
    logic [NC-1:0] cmask_q;

    // causes the host can see right now
    always_comb begin
        shown = chan_hide ? '0 : (pend_q & ~cmask_q);
    end

    // only the shown causes are cleared; a coincident event is set again
    always_comb begin
        pend_d = (pend_q & ~(clr ? shown : '0)) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            cmask_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (mask_we) begin
                cmask_q <= mask_wdata;
            end
        end
    end

    assign cmask = cmask_q;
endmodule

// File: rtl/chan_irq_bus.sv
module chan_irq_bus
    import chan_irq_pkg::*;
(
    input  logic                         rd,
    input  reg_sel_t                     sel,
    input  logic [NCH-1:0][NCAUSE-1:0]   shown,
    input  logic [NCH-1:0][NCAUSE-1:0]   cmask,
    input  logic [NCH-1:0]               vec,
    input  logic [NCH-1:0]               chmask,
    input  logic                         cfg_hi,
    output logic [DW-1:0]                rdata,
    output logic [DW-1:0]                oe
);
    always_comb begin
        rdata = '0;
        oe    = '0;
        if (rd) begin
            oe = '1;
            unique case (sel.kind)
                RK_STAT:   rdata = DW'(shown[sel.chan]);
                RK_CMASK:  rdata = DW'(cmask[sel.chan]);
                RK_VEC: begin
                    rdata = cfg_hi ? (DW'(vec) << VSH) : DW'(vec);
                    oe    = cfg_hi ? (VEC_OE_LO << VSH) : VEC_OE_LO;
                end
                RK_CHMASK: rdata = DW'(chmask);
                RK_CFG:    rdata = DW'(cfg_hi);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
    import chan_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH*NCAUSE-1:0] evt,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [DW-1:0]         bus_oe,
    output logic                  irq_drv_low
);
    reg_sel_t                     sel;
    logic [NCH-1:0][NCAUSE-1:0]   shown;
    logic [NCH-1:0][NCAUSE-1:0]   cmask_a;
    logic [NCH*NCAUSE-1:0]        cmask_flat;
    logic [NCH-1:0]               vis_vec;
    logic [NCH-1:0]               chmask_q;
    logic                         cfg_hi_q;

    assign sel = decode_addr(bus_addr);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic clr_c;
        logic we_c;
        assign clr_c = bus_rd && (sel.kind == RK_STAT)  && (sel.chan == CHW'(c));
        assign we_c  = bus_wr && (sel.kind == RK_CMASK) && (sel.chan == CHW'(c));

        chan_irq_cell #(.NC(NCAUSE)) u_cell (
            .clk        (clk),
            .rst        (rst),
            .evt        (evt[c*NCAUSE +: NCAUSE]),
            .chan_hide  (chmask_q[c]),
            .clr        (clr_c),
            .mask_we    (we_c),
            .mask_wdata (bus_wdata[NCAUSE-1:0]),
            .shown      (shown[c]),
            .cmask      (cmask_a[c])
        );

        assign vis_vec[c] = |shown[c];
        assign cmask_flat[c*NCAUSE +: NCAUSE] = cmask_a[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chmask_q <= '0;
            cfg_hi_q <= 1'b0;
        end else if (bus_wr) begin
            if (sel.kind == RK_CHMASK) begin
                chmask_q <= bus_wdata[NCH-1:0];
            end
            if (sel.kind == RK_CFG) begin
                cfg_hi_q <= bus_wdata[0];
            end
        end
    end

    chan_irq_bus u_bus (
        .rd     (bus_rd),
        .sel    (sel),
        .shown  (shown),
        .cmask  (cmask_a),
        .vec    (vis_vec),
        .chmask (chmask_q),
        .cfg_hi (cfg_hi_q),
        .rdata  (bus_rdata),
        .oe     (bus_oe)
    );

    assign irq_drv_low = |vis_vec;
endmodule

// File: rtl/chan_irq_hub_chk.sv
module chan_irq_hub_chk
    import chan_irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NCH*NCAUSE-1:0] evt,
    input logic                  bus_rd,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_rdata,
    input logic [DW-1:0]         bus_oe,
    input logic                  irq_drv_low,
    input logic [NCH-1:0]        vis_vec,
    input logic [NCH-1:0]        chmask_q,
    input logic                  cfg_hi_q,
    input logic [NCH*NCAUSE-1:0] cmask_flat
);
    logic [NCH-1:0] ev_vis;
    logic [NCH-1:0] ev_any;
    logic [NCH-1:0] rd_st;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ev_any[c] = |evt[c*NCAUSE +: NCAUSE];
            ev_vis[c] = !chmask_q[c] &&
                        (|(evt[c*NCAUSE +: NCAUSE] & ~cmask_flat[c*NCAUSE +: NCAUSE]));
            rd_st[c]  = bus_rd && (bus_addr == AW'(c));
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_a
        AST_EVT_RAISES: assert property (@(posedge clk) disable iff (rst)
            (ev_vis[c] && !bus_wr) |=> (vis_vec[c] && irq_drv_low)); // R1
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (rd_st[c] && !ev_any[c] && !bus_wr) |=> !vis_vec[c]); // R2
        AST_NEW_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
            (rd_st[c] && ev_vis[c] && !bus_wr) |=> vis_vec[c]); // R3
        AST_HIDDEN_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rd_st[c] && chmask_q[c]) |-> (bus_rdata == '0)); // R5
    end

    AST_VEC_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_VEC) |->
        (bus_oe == (cfg_hi_q ? (VEC_OE_LO << VSH) : VEC_OE_LO))); // R6
    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_oe == '0)); // R7
    AST_VEC_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_VEC && evt == '0 && !bus_wr) |=>
        (vis_vec == $past(vis_vec))); // R9
endmodule

bind chan_irq_hub chan_irq_hub_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt         (evt),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_oe      (bus_oe),
    .irq_drv_low (irq_drv_low),
    .vis_vec     (vis_vec),
    .chmask_q    (chmask_q),
    .cfg_hi_q    (cfg_hi_q),
    .cmask_flat  (cmask_flat)
);

// File: tb/chan_irq_hub_test.sv
module chan_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] evt = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  bus_oe;
    logic        irq_drv_low;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [4:0] m_pend [4];
    logic [4:0] m_cm   [4];
    logic [3:0] m_chm;
    logic       m_cfg;

    always #2.5 clk = ~clk;

    chan_irq_hub uut (
        .clk(clk), .rst(rst), .evt(evt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .irq_drv_low(irq_drv_low)
    );

    function automatic logic [4:0] vis(input int c);
        return m_chm[c] ? 5'd0 : (m_pend[c] & ~m_cm[c]);
    endfunction

    function automatic logic [3:0] vec_of();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = |vis(c);
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_pend[c] = '0;
            m_cm[c]   = '0;
        end
        m_chm = '0;
        m_cfg = 1'b0;
    endtask

    // one bus cycle: drive, check the combinational outputs, update the model
    task automatic cyc(input logic [19:0] ev, input logic rd, input logic wr,
                       input logic [3:0] addr, input logic [7:0] wd, input string tag);
        logic [7:0] ed;
        logic [7:0] eo;
        @(negedge clk);
        evt = ev; bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        #1;
        chk(tag, "irq", int'(irq_drv_low), int'(|vec_of()));
        ed = 8'h00;
        eo = 8'h00;
        if (rd) begin
            eo = 8'hFF;
            if (addr < 4)        ed = {3'b0, vis(int'(addr))};
            else if (addr < 8)   ed = {3'b0, m_cm[addr-4]};
            else if (addr == 8) begin
                ed = m_cfg ? {vec_of(), 4'h0} : {4'h0, vec_of()};
                eo = m_cfg ? 8'hF0 : 8'h0F;
            end
            else if (addr == 9)  ed = {4'h0, m_chm};
            else if (addr == 10) ed = {7'h0, m_cfg};
        end
        chk(tag, "oe", int'(bus_oe), int'(eo));
        if (rd) chk(tag, "rdata", int'(bus_rdata), int'(ed));
        if (rd && addr < 4) m_pend[addr] = m_pend[addr] & ~vis(int'(addr));
        for (int c = 0; c < 4; c++) m_pend[c] = m_pend[c] | ev[c*5 +: 5];
        if (wr) begin
            if (addr >= 4 && addr < 8) m_cm[addr-4] = wd[4:0];
            else if (addr == 9)        m_chm = wd[3:0];
            else if (addr == 10)       m_cfg = wd[0];
        end
    endtask

    function automatic logic [19:0] ebit(input int c, input int k);
        return 20'(1) << (c * 5 + k);
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state, R7: idle bus undriven
        cyc('0, 0, 0, 4'd0, 8'h00, "R8");
        for (int a = 0; a < 11; a++) cyc('0, 1, 0, 4'(a), 8'h00, "R8");

        // R1 / R2 / R6: single event, vector then cause read clears
        cyc(ebit(2, 3), 0, 0, 4'd0, 8'h00, "R1");
        cyc('0, 1, 0, 4'd8, 8'h00, "R1");
        cyc('0, 1, 0, 4'd2, 8'h00, "R2");
        cyc('0, 1, 0, 4'd2, 8'h00, "R2");

        // R3: event arriving with the clearing read survives
        cyc(ebit(1, 0), 0, 0, 4'd0, 8'h00, "R3");
        cyc(ebit(1, 0) | ebit(1, 2), 1, 0, 4'd1, 8'h00, "R3");
        cyc('0, 1, 0, 4'd1, 8'h00, "R3");

        // R10: clearing one channel leaves another
        cyc(ebit(0, 1) | ebit(3, 4), 0, 0, 4'd0, 8'h00, "R10");
        cyc('0, 1, 0, 4'd0, 8'h00, "R10");
        cyc('0, 1, 0, 4'd8, 8'h00, "R10");
        cyc('0, 1, 0, 4'd3, 8'h00, "R10");

        // R4: masked cause stays pending, shows after unmask
        cyc('0, 0, 1, 4'd5, 8'h02, "R4");
        cyc(ebit(1, 1), 0, 0, 4'd0, 8'h00, "R4");
        cyc('0, 1, 0, 4'd1, 8'h00, "R4");
        cyc('0, 1, 0, 4'd8, 8'h00, "R4");
        cyc('0, 1, 0, 4'd5, 8'h00, "R4");
        cyc('0, 0, 1, 4'd5, 8'h00, "R4");
        cyc('0, 1, 0, 4'd1, 8'h00, "R4");

        // R5: hidden channel
        cyc('0, 0, 1, 4'd9, 8'h01, "R5");
        cyc(ebit(0, 4), 0, 0, 4'd0, 8'h00, "R5");
        cyc('0, 1, 0, 4'd0, 8'h00, "R5");
        cyc('0, 1, 0, 4'd8, 8'h00, "R5");
        cyc('0, 0, 1, 4'd9, 8'h00, "R5");
        cyc('0, 1, 0, 4'd8, 8'h00, "R5");
        cyc('0, 1, 0, 4'd0, 8'h00, "R5");

        // R6 / R9: upper nibble vector, repeated vector read
        cyc('0, 0, 1, 4'd10, 8'h01, "R6");
        cyc(ebit(3, 0), 0, 0, 4'd0, 8'h00, "R6");
        cyc('0, 1, 0, 4'd8, 8'h00, "R6");
        cyc('0, 1, 0, 4'd8, 8'h00, "R9");
        cyc('0, 1, 0, 4'd10, 8'h00, "R6");
        cyc('0, 1, 0, 4'd3, 8'h00, "R2");

        // R7: full drive on other reads, unused addresses read 0
        cyc('0, 1, 0, 4'd9, 8'h00, "R7");
        cyc('0, 1, 0, 4'd15, 8'h00, "R7");
        cyc('0, 1, 0, 4'd11, 8'h00, "R7");

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] ev;
            int op;
            int ch;
            ev = ($urandom % 5 == 0) ? (20'(1) << ($urandom % 20)) : 20'd0;
            op = $urandom % 10;
            ch = $urandom % 4;
            case (op)
                0, 1, 2, 3: cyc(ev, 1, 0, 4'(ch), 8'h00, "rand R2");
                4:          cyc(ev, 1, 0, 4'd8, 8'h00, "rand R6");
                5:          cyc(ev, 0, 1, 4'(4 + ch),
                                ($urandom % 3 == 0) ? 8'($urandom) : 8'h00, "rand R4");
                6:          cyc(ev, 0, 1, 4'd9,
                                ($urandom % 3 == 0) ? 8'($urandom) : 8'h00, "rand R5");
                7:          cyc(ev, 0, 1, 4'd10, 8'($urandom), "rand R6");
                8:          cyc(ev, 1, 0, 4'($urandom % 16), 8'h00, "rand R7");
                default:    cyc(ev, 0, 0, 4'd0, 8'h00, "rand R1");
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule